// File: doc/BRIEF.md
# Configurable Lookup-Table Logic Cell

This block models one cell of a programmable fabric. It has two 4-input lookup tables, a carry path for chaining cells, and two one-bit storage elements. What it does is set by a 47-bit configuration word that is shifted in one bit per clock at start-up. The word selects each table's truth table and whether the table also acts as a 16-bit writable memory. It also sets each storage element's mode, enable behaviour, set/reset style and start value. Table 1 can drive the carry output, so two cells loaded with full-adder tables form a ripple adder.

The word is shifted in while `cfg_en_i` is high. A one-cycle `cfg_done_i` pulse then arms the cell. Until that pulse, every output stays at 0. Each storage element is an edge-triggered flip-flop or a gated transparent element, chosen by configuration. In transparent mode the output follows the value the element would capture while its clock enable is high, and holds the last captured value once the enable is low.

Top module: `lut_cell`

## Requirements
- R1: While `cfg_en_i` is high, one bit of `cfg_sdi_i` is shifted in on each rising clock edge, most significant bit first. The word is [46] carry-from-table-1 and [45:23] table 1 settings over [22:0] table 0 settings. Each 23-bit half is, from MSB down: memory enable, carry-in substitution, stored-output select, transparent mode, asynchronous set/reset, forced set/reset value, start value, and the 16 table bits.
- R2: After reset, on the edge after any cycle with `cfg_en_i` high, and until a `cfg_done_i` pulse arrives with `cfg_en_i` low, `comb_o`, `out_o` and `cout_o` are all 0.
- R3: `comb_o[h]` is table bit number A, where A = {din[3], s ? cin_i : din[2], din[1], din[0]} and s is that table's carry-in substitution bit.
- R4: `cout_o` equals `comb_o[1]` when the carry-from-table-1 bit is 1, and equals `cin_i` otherwise.
- R5: Two cells, each with table 0 = 16'h9696 and table 1 = 16'hE8E8, substitution on in both tables, carry from table 1 on, and cells chained cout to cin, give the correct 3-bit sum of any two 2-bit operands.
- R6: With memory enable set, a rising edge with `we_i[h]` high writes `wd_i[h]` into the table at the current address A, and reads stay combinational. With memory enable clear, `we_i[h]` has no effect.
- R7: The edge that accepts `cfg_done_i` loads each storage element with its configured start value.
- R8: In flip-flop mode the element captures the table result on an edge where `ce_i[h]` is high, and holds when `ce_i[h]` is low.
- R9: In transparent mode, while `ce_i[h]` is high the stored view follows the value to be captured, before the edge. While `ce_i[h]` is low it shows the held value.
- R10: With synchronous set/reset, `sr_i[h]` forces the configured value in place of the data only on an edge where `ce_i[h]` is high. With `ce_i[h]` low it has no effect.
- R11: With asynchronous set/reset, `sr_i[h]` forces the configured value at once, whatever the clock and enable are doing, and the value stays after release.
- R12: `out_o[h]` is the stored view when the stored-output select bit is 1, and is `comb_o[h]` otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_en_i | input | 1 | Configuration shift enable |
| cfg_sdi_i | input | 1 | Configuration serial data |
| cfg_done_i | input | 1 | Configuration complete pulse |
| din0_i | input | 4 | Table 0 inputs |
| din1_i | input | 4 | Table 1 inputs |
| cin_i | input | 1 | Carry input |
| ce_i | input | 2 | Clock enable per storage element |
| sr_i | input | 2 | Set/reset request per storage element |
| we_i | input | 2 | Memory write enable per table |
| wd_i | input | 2 | Memory write data per table |
| comb_o | output | 2 | Direct table results |
| out_o | output | 2 | Selected outputs (table or stored) |
| cout_o | output | 1 | Carry output |

## Verification
Two pairs of functions can act in the same cycle. A memory write can land on the same edge on which the storage element captures the table result, and the capture must use the value from before the write. An asynchronous set/reset can also be held while the clock enable is high, and the forced value must win over the transparent view. The bench provokes both by writing table addresses with the capture enabled, and by raising the asynchronous request during enabled cycles. Its behavioural reference model judges the outputs before every edge.

// File: rtl/lut_cell_pkg.sv
package lut_cell_pkg;
    parameter int unsigned LC_K      = 4;
    parameter int unsigned LC_HALVES = 2;
    parameter int unsigned LC_CIN_POS = 2;
    localparam int unsigned LC_ENT = 1 << LC_K;

    typedef struct packed {
        logic              mem_en;
        logic              cin_sel;
        logic              out_reg;
        logic              latch_mode;
        logic              async_sr;
        logic              sr_val;
        logic              init_val;
        logic [LC_ENT-1:0] tbl;
    } lc_half_t;

    typedef struct packed {
        logic                       carry_lut;
        lc_half_t [LC_HALVES-1:0]   half;
    } lc_cfg_t;

    localparam int unsigned LC_CFG_W = $bits(lc_cfg_t);
endpackage

// File: rtl/lc_cfg.sv
module lc_cfg
    import lut_cell_pkg::*;
(
    input  logic                                clk_i,
    input  logic                                rst_ni,
    input  logic                                cfg_en_i,
    input  logic                                cfg_sdi_i,
    input  logic                                cfg_done_i,
    input  logic [LC_HALVES-1:0][LC_K-1:0]      addr_i,
    input  logic [LC_HALVES-1:0]                we_i,
    input  logic [LC_HALVES-1:0]                wd_i,
    output lc_cfg_t                             cfg_o,
    output logic                                ok_o
);
    typedef struct packed {
        lc_cfg_t cfg;
        logic    ok;
    } cfg_state_t;

    cfg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cfg_en_i) begin
            st_d.cfg = {st_q.cfg[LC_CFG_W-2:0], cfg_sdi_i};
            st_d.ok  = 1'b0;
        end else if (cfg_done_i) begin
            st_d.ok = 1'b1;
        end else if (st_q.ok) begin
            for (int h = 0; h < LC_HALVES; h++) begin
                if (st_q.cfg.half[h].mem_en && we_i[h]) begin
                    st_d.cfg.half[h].tbl[addr_i[h]] = wd_i[h];
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign cfg_o = st_q.cfg;
    assign ok_o  = st_q.ok;
endmodule

// File: rtl/lc_lut.sv
module lc_lut
    import lut_cell_pkg::*;
(
    input  logic [LC_ENT-1:0] tbl_i,
    input  logic              cin_sel_i,
    input  logic [LC_K-1:0]   din_i,
    input  logic              cin_i,
    output logic [LC_K-1:0]   addr_o,
    output logic              bit_o
);
    for (genvar i = 0; i < LC_K; i++) begin : g_addr
        if (i == LC_CIN_POS) begin : g_cin
            assign addr_o[i] = cin_sel_i ? cin_i : din_i[i];
        end else begin : g_plain
            assign addr_o[i] = din_i[i];
        end
    end

    assign bit_o = tbl_i[addr_o];
endmodule

// File: rtl/lc_store.sv
module lc_store (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic arst_i,
    input  logic srval_i,
    input  logic load_i,
    input  logic init_i,
    input  logic run_i,
    input  logic ce_i,
    input  logic sync_sr_i,
    input  logic d_i,
    output logic q_o,
    output logic nxt_o
);
    logic q_d, q_q;

    always_comb begin
        q_d = q_q;
        if (load_i) begin
            q_d = init_i;
        end else if (run_i && ce_i) begin
            q_d = sync_sr_i ? srval_i : d_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni or posedge arst_i) begin
        if (!rst_ni)     q_q <= 1'b0;
        else if (arst_i) q_q <= srval_i;
        else             q_q <= q_d;
    end

    assign q_o   = q_q;
    assign nxt_o = q_d;
endmodule

// File: rtl/lut_cell.sv
module lut_cell
    import lut_cell_pkg::*;
(
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 cfg_en_i,
    input  logic                 cfg_sdi_i,
    input  logic                 cfg_done_i,
    input  logic [LC_K-1:0]      din0_i,
    input  logic [LC_K-1:0]      din1_i,
    input  logic                 cin_i,
    input  logic [LC_HALVES-1:0] ce_i,
    input  logic [LC_HALVES-1:0] sr_i,
    input  logic [LC_HALVES-1:0] we_i,
    input  logic [LC_HALVES-1:0] wd_i,
    output logic [LC_HALVES-1:0] comb_o,
    output logic [LC_HALVES-1:0] out_o,
    output logic                 cout_o
);
    lc_cfg_t                          cfg_q;
    logic                             cfg_ok;
    logic                             run;
    logic                             load;
    logic [LC_HALVES-1:0][LC_K-1:0]   din;
    logic [LC_HALVES-1:0][LC_K-1:0]   addr;
    logic [LC_HALVES-1:0]             tbl_bit;
    logic [LC_HALVES-1:0]             arst;
    logic [LC_HALVES-1:0]             sync_sr;
    logic [LC_HALVES-1:0]             st_q;
    logic [LC_HALVES-1:0]             nxt;
    logic [LC_HALVES-1:0]             view;

    assign din[0] = din0_i;
    assign din[1] = din1_i;
    assign run    = cfg_ok & ~cfg_en_i;
    assign load   = cfg_done_i & ~cfg_en_i;

    lc_cfg u_cfg (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .cfg_en_i   (cfg_en_i),
        .cfg_sdi_i  (cfg_sdi_i),
        .cfg_done_i (cfg_done_i),
        .addr_i     (addr),
        .we_i       (we_i),
        .wd_i       (wd_i),
        .cfg_o      (cfg_q),
        .ok_o       (cfg_ok)
    );

    for (genvar h = 0; h < LC_HALVES; h++) begin : g_half
        lc_lut u_lut (
            .tbl_i     (cfg_q.half[h].tbl),
            .cin_sel_i (cfg_q.half[h].cin_sel),
            .din_i     (din[h]),
            .cin_i     (cin_i),
            .addr_o    (addr[h]),
            .bit_o     (tbl_bit[h])
        );

        assign arst[h]    = cfg_ok & cfg_q.half[h].async_sr & sr_i[h];
        assign sync_sr[h] = sr_i[h] & ~cfg_q.half[h].async_sr;

        lc_store u_store (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .arst_i    (arst[h]),
            .srval_i   (cfg_q.half[h].sr_val),
            .load_i    (load),
            .init_i    (cfg_q.half[h].init_val),
            .run_i     (run),
            .ce_i      (ce_i[h]),
            .sync_sr_i (sync_sr[h]),
            .d_i       (tbl_bit[h]),
            .q_o       (st_q[h]),
            .nxt_o     (nxt[h])
        );

        assign view[h] = arst[h] ? cfg_q.half[h].sr_val :
                         (cfg_q.half[h].latch_mode && run && ce_i[h]) ? nxt[h] : st_q[h];

        assign comb_o[h] = cfg_ok & tbl_bit[h];
        assign out_o[h]  = cfg_ok & (cfg_q.half[h].out_reg ? view[h] : tbl_bit[h]);
    end

    assign cout_o = cfg_ok & (cfg_q.carry_lut ? tbl_bit[1] : cin_i);
endmodule

// File: rtl/lut_cell_chk.sv
module lut_cell_chk
    import lut_cell_pkg::*;
(
    input logic                             clk_i,
    input logic                             rst_ni,
    input logic                             cfg_en_i,
    input logic                             cfg_done_i,
    input logic [LC_HALVES-1:0]             ce_i,
    input logic [LC_HALVES-1:0]             sr_i,
    input logic [LC_HALVES-1:0]             we_i,
    input logic [LC_HALVES-1:0]             wd_i,
    input lc_cfg_t                          cfg_q,
    input logic                             cfg_ok,
    input logic [LC_HALVES-1:0]             st_q,
    input logic [LC_HALVES-1:0][LC_K-1:0]   addr,
    input logic [LC_HALVES-1:0]             comb_o,
    input logic [LC_HALVES-1:0]             out_o,
    input logic                             cout_o
);
    a_r2_held_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg_en_i |=> (comb_o == '0 && out_o == '0 && cout_o == 1'b0));

    for (genvar h = 0; h < LC_HALVES; h++) begin : g_chk
        a_r7_start_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (cfg_done_i && !cfg_en_i && !(cfg_ok && cfg_q.half[h].async_sr && sr_i[h]))
            |=> ((cfg_q.half[h].async_sr && sr_i[h]) || st_q[h] == $past(cfg_q.half[h].init_val)));

        a_r8_hold_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (cfg_ok && !cfg_en_i && !cfg_done_i && !ce_i[h] &&
             !(cfg_q.half[h].async_sr && sr_i[h]))
            |=> ((cfg_q.half[h].async_sr && sr_i[h]) || st_q[h] == $past(st_q[h])));

        a_r10_sync_force: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (cfg_ok && !cfg_en_i && !cfg_done_i && ce_i[h] && sr_i[h] && !cfg_q.half[h].async_sr)
            |=> st_q[h] == $past(cfg_q.half[h].sr_val));

        a_r11_async_force: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (cfg_ok && cfg_q.half[h].async_sr && sr_i[h]) |-> st_q[h] == cfg_q.half[h].sr_val);

        a_r6_mem_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (cfg_ok && !cfg_en_i && !cfg_done_i && cfg_q.half[h].mem_en && we_i[h])
            |=> cfg_q.half[h].tbl[$past(addr[h])] == $past(wd_i[h]));
    end
endmodule

bind lut_cell lut_cell_chk chk_i (.*);

// File: tb/lut_cell_tb_top.sv
module lut_cell_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       cfg_en, cfg_sdi, cfg_done, hi_en;
    logic [3:0] din0, din1, din0_hi;
    logic       cin;
    logic [1:0] ce, sr, we, wd;
    logic [1:0] comb, outv, hi_comb, hi_out;
    logic       cout, hi_cout;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    lut_cell dut_i (
        .clk_i(clk), .rst_ni(rst_n), .cfg_en_i(cfg_en), .cfg_sdi_i(cfg_sdi),
        .cfg_done_i(cfg_done), .din0_i(din0), .din1_i(din1), .cin_i(cin),
        .ce_i(ce), .sr_i(sr), .we_i(we), .wd_i(wd),
        .comb_o(comb), .out_o(outv), .cout_o(cout)
    );

    lut_cell dut_hi_i (
        .clk_i(clk), .rst_ni(rst_n), .cfg_en_i(hi_en), .cfg_sdi_i(cfg_sdi),
        .cfg_done_i(cfg_done), .din0_i(din0_hi), .din1_i(din0_hi), .cin_i(cout),
        .ce_i(2'b00), .sr_i(2'b00), .we_i(2'b00), .wd_i(2'b00),
        .comb_o(hi_comb), .out_o(hi_out), .cout_o(hi_cout)
    );

    // behavioural reference state
    logic [46:0] m_cfg = '0;
    bit          m_ok  = 0;
    bit   [1:0]  m_st  = '0;

    function automatic int base(int h); return h * 23; endfunction
    function automatic bit fld(int h, int off); return m_cfg[base(h) + off]; endfunction

    function automatic int m_addr(int h);
        logic [3:0] a;
        a = (h == 0) ? din0 : din1;
        if (fld(h, 21)) a[2] = cin;
        return int'(a);
    endfunction

    function automatic bit m_tbl(int h);
        return m_cfg[base(h) + m_addr(h)];
    endfunction

    function automatic logic [22:0] mk_half(bit mem, bit csel, bit oreg, bit lat,
                                            bit asy, bit srv, bit ini, logic [15:0] t);
        return {mem, csel, oreg, lat, asy, srv, ini, t};
    endfunction

    task automatic check(string tag);
        logic [4:0] exp_v, act_v;
        bit t, arst, run, v;
        for (int h = 0; h < 2; h++) begin
            t    = m_tbl(h);
            arst = m_ok && fld(h, 18) && sr[h];
            run  = m_ok && !cfg_en;
            if (arst) v = fld(h, 17);
            else if (fld(h, 19) && run && ce[h]) v = (sr[h] && !fld(h, 18)) ? fld(h, 17) : t;
            else v = m_st[h];
            exp_v[h]     = m_ok ? t : 1'b0;
            exp_v[2 + h] = m_ok ? (fld(h, 20) ? v : t) : 1'b0;
        end
        exp_v[4] = m_ok ? (m_cfg[46] ? m_tbl(1) : cin) : 1'b0;
        act_v = {cout, outv, comb};
        checks++;
        if (act_v !== exp_v) begin
            fails++;
            $display("FAIL %s t=%0t actual={cout,out,comb}=%b expected=%b", tag, $time, act_v, exp_v);
        end
    endtask

    task automatic model_edge();
        bit t [2];
        for (int h = 0; h < 2; h++) t[h] = m_tbl(h);
        for (int h = 0; h < 2; h++) begin
            if (m_ok && fld(h, 18) && sr[h]) m_st[h] = fld(h, 17);
            else if (cfg_done && !cfg_en) m_st[h] = fld(h, 16);
            else if (m_ok && !cfg_en && ce[h]) m_st[h] = (sr[h] && !fld(h, 18)) ? fld(h, 17) : t[h];
        end
        if (cfg_en) begin
            m_cfg = {m_cfg[45:0], cfg_sdi};
            m_ok  = 0;
        end else if (cfg_done) begin
            m_ok = 1;
        end else if (m_ok) begin
            for (int h = 0; h < 2; h++)
                if (fld(h, 22) && we[h]) m_cfg[base(h) + m_addr(h)] = wd[h];
        end
    endtask

    // inputs set at negedge+1; compared at negedge+2; model steps at the edge
    task automatic tick(string tag);
        #1;
        check(tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        #1;
    endtask

    task automatic load(logic [46:0] w, bit both);
        for (int i = 46; i >= 0; i--) begin
            cfg_en = 1'b1; hi_en = both; cfg_sdi = w[i];
            tick("R2");
        end
        cfg_en = 1'b0; hi_en = 1'b0; cfg_done = 1'b1;
        tick("R2");
        cfg_done = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            fails++; checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [46:0] w;
        int s;
        rst_n = 1'b0; cfg_en = 0; hi_en = 0; cfg_sdi = 0; cfg_done = 0;
        din0 = '0; din1 = '0; din0_hi = '0; cin = 0; ce = '0; sr = '0; we = '0; wd = '0;
        #11;
        rst_n = 1'b1;
        tick("R2");                                  // reset state, outputs 0

        // R1: word 1 - AND4 flip-flop with sync reset; XOR4 transparent with async set
        w = {1'b0, mk_half(0,0,1,1,1,1,0,16'h6996), mk_half(0,0,1,0,0,0,1,16'h8000)};
        load(w, 0);
        tick("R7");                                  // start values visible
        din0 = 4'hF; din1 = 4'h1; ce = 2'b11; tick("R8");
        din0 = 4'h7; tick("R8");
        ce = 2'b00; din0 = 4'hF; tick("R8");         // hold while disabled
        tick("R8");
        ce = 2'b10; din1 = 4'h3; tick("R9");         // transparent follows
        din1 = 4'h7; tick("R9");
        ce = 2'b00; din1 = 4'h6; tick("R9");         // holds
        tick("R12");
        ce = 2'b01; din0 = 4'hF; tick("R8");         // load a 1
        ce = 2'b00; sr = 2'b01; tick("R10");         // no effect without enable
        tick("R10");
        ce = 2'b01; tick("R10");                     // forced to 0 on enabled edge
        sr = 2'b00; ce = 2'b00; tick("R10");
        ce = 2'b10; din1 = 4'h0; tick("R9");
        ce = 2'b00; sr = 2'b10; tick("R11");         // immediate set
        sr = 2'b00; tick("R11");                     // stays after release
        ce = 2'b10; sr = 2'b10; tick("R11");         // async wins over transparent view
        sr = 2'b00; ce = 2'b00;
        cin = 1; tick("R4"); cin = 0; tick("R4");

        // word 2 - table 0 as memory, table 1 with carry-in substitution, cout from table 1
        w = {1'b1, mk_half(0,1,0,0,0,0,0,16'hF0F0), mk_half(1,0,0,0,0,0,0,16'h0000)};
        load(w, 0);
        din1 = 4'h0; cin = 1; tick("R3");
        cin = 0; tick("R3");
        din1 = 4'h4; tick("R3");                     // bit 2 replaced by cin
        cin = 1; din1 = 4'h1; tick("R4");
        for (int a = 0; a < 16; a++) begin
            din0 = 4'(a); we = 2'b11; wd = {1'b1, 1'(a ^ (a >> 2))}; ce = 2'b01;
            tick("R6");
        end
        we = 2'b00;
        for (int a = 0; a < 16; a++) begin
            din0 = 4'(a); din1 = 4'(a); tick("R6");
        end
        ce = 2'b00;

        // word 3 - two-cell ripple adder
        w = {1'b1, mk_half(0,1,0,0,0,0,0,16'hE8E8), mk_half(0,1,0,0,0,0,0,16'h9696)};
        cin = 0;
        load(w, 1);
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 4; b++) begin
                din0    = {2'b00, 1'(b), 1'(a)};
                din1    = din0;
                din0_hi = {2'b00, 1'(b >> 1), 1'(a >> 1)};
                #1;
                s = int'({hi_cout, hi_comb[0], comb[0]});
                checks++;
                if (s != a + b) begin
                    fails++;
                    $display("FAIL R5 %0d+%0d actual=%0d expected=%0d", a, b, s, a + b);
                end
                tick("R5");
            end
        end

        cfg_en = 1'b1; tick("R2");
        tick("R2");
        cfg_en = 1'b0;

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule